// File: doc/BRIEF.md
# Fabric Configuration Session Sequencer

This block steps a programmable fabric through the hardware side of a configuration session. A one-cycle start pulse opens a session. In full mode the sequencer first asserts all four fabric interface resets. It then closes the isolation level shifters and opens only the processor-to-fabric direction. Next it runs a three-edge handshake on an active-low program strobe, watching an init-status input that follows the strobe. It then waits for the fabric to report that programming is done. Finally it opens both shifter directions and releases the resets. In partial mode the resets, shifters and strobe are left as they are, and the session only waits for programming-done.

Every wait is a poll. The status input is sampled once per poll interval, and the wait fails after a fixed number of polls. The interval and the overall timeout are given in microseconds and converted to clock cycles with a cycles-per-microsecond parameter. Control and status pins are plain levels. There is no data path and so no valid/ready stream; the bitstream transfer runs elsewhere. A busy level covers the whole session, and it ends with a sticky success or error flag.

Top module: `fabric_cfg_seq`

## Requirements
- R1: After reset: busy, ok and err are 0, the reset vector is 4'h0, the shifter vector is 4'h0 and the program strobe is 1.
- R2: A full-mode start sets the reset vector to 4'hF in the start cycle, before the shifter vector changes.
- R3: After the resets, the shifter vector is written to 4'h0 and then to 4'hA (bits 3 and 1 open processor-to-fabric), one step per cycle. The program strobe is low only while the shifter vector is 4'hA and the resets are 4'hF.
- R4: The handshake drives the strobe high and waits for init high, then drives it low and waits for init low, then drives it high and waits for init high. Init is sampled only at poll ticks, which are POLL_US*CYC_PER_US cycles apart.
- R5: If an init wait fails, the session ends with err=1 and busy=0. The reset vector stays 4'hF, the shifter vector keeps its last value and the strobe returns high.
- R6: Once programming-done is seen in a full session, the shifter vector becomes 4'hF, and one cycle later the reset vector becomes 4'h0 with ok=1 and busy=0.
- R7: In partial mode the reset vector, the shifter vector and the strobe never change. The session ends with ok=1 when programming-done is seen.
- R8: The programming-done wait has the same poll timeout, and a failure there ends the session with err=1.
- R9: busy is 1 from the cycle after the accepted start until ok or err is set, and ok and err are 0 while it is 1. Start pulses and changes of the partial flag during a session are ignored.
- R10: ok and err never hold together. Each stays set until the next accepted start clears it.
- R11: A wait fails on the (TIMEOUT_US/POLL_US)-th poll tick after it begins. A full session whose first init wait never succeeds is busy for 3 + POLL_CYC*MAX_POLLS cycles; a partial session whose done wait never succeeds is busy for POLL_CYC*MAX_POLLS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse, accepted only when idle |
| partial_i | input | 1 | Partial-mode select, sampled with start |
| init_sts_i | input | 1 | Fabric init status |
| prog_done_i | input | 1 | Fabric programming-done status |
| rst_vec_o | output | 4 | Fabric interface resets, 1 = asserted |
| iso_en_o | output | 4 | Level-shifter enables |
| prog_n_o | output | 1 | Active-low program strobe |
| busy_o | output | 1 | Session in progress |
| ok_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with CYC_PER_US=1, POLL_US=2 and TIMEOUT_US=20. That gives a two-cycle poll interval and a ten-poll timeout, so every wait state can be made to fail within a few dozen cycles. A fabric model in the bench echoes the strobe onto init with a delay. It can also hold init low, hold it high, or stop it rising after its first fall, which reaches the timeout of each of the three handshake waits and of the done wait. The exact busy length of a timed-out session checks the poll spacing and the poll count together.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam int VEC_W = 4;

  localparam logic [VEC_W-1:0] RST_ALL    = 4'hF;
  localparam logic [VEC_W-1:0] RST_NONE   = 4'h0;
  localparam logic [VEC_W-1:0] ISO_CLOSED = 4'h0;
  localparam logic [VEC_W-1:0] ISO_FWD    = 4'hA;
  localparam logic [VEC_W-1:0] ISO_BOTH   = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ISO_CLOSE,
    ST_ISO_FWD,
    ST_PROG_REL,
    ST_INIT_HI1,
    ST_INIT_LO,
    ST_INIT_HI2,
    ST_DONE_WAIT,
    ST_ISO_BOTH,
    ST_RST_REL
  } seq_state_e;

endpackage

// File: rtl/cfgseq_poll_timer.sv
module cfgseq_poll_timer #(
  parameter int POLL_CYC  = 2000,
  parameter int MAX_POLLS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o,
  output logic last_poll_o
);

  localparam int CW = (POLL_CYC  > 1) ? $clog2(POLL_CYC)  : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] CYC_LAST  = CW'(POLL_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] polls_q;

  assign tick_o      = (cyc_q == CYC_LAST);
  assign last_poll_o = (polls_q == POLL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      polls_q <= '0;
    end else if (restart_i) begin
      cyc_q   <= '0;
      polls_q <= '0;
    end else if (tick_o) begin
      cyc_q <= '0;
      if (!last_poll_o) polls_q <= polls_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  AST_POLLS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= POLL_LAST); // R11

  AST_CYC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_LAST); // R4

endmodule

// File: rtl/cfgseq_wait_eval.sv
module cfgseq_wait_eval
  import cfgseq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       init_i,
  input  logic       done_i,
  output logic       waiting_o,
  output logic       met_o
);

  always_comb begin
    waiting_o = 1'b1;
    met_o     = 1'b0;
    unique case (state_i)
      ST_INIT_HI1:  met_o = init_i;
      ST_INIT_LO:   met_o = !init_i;
      ST_INIT_HI2:  met_o = init_i;
      ST_DONE_WAIT: met_o = done_i;
      default:      waiting_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic             tick_i,
  input  logic             last_poll_i,
  input  logic             waiting_i,
  input  logic             met_i,
  output seq_state_e       state_o,
  output logic             tmr_restart_o,
  output logic [VEC_W-1:0] rst_vec_o,
  output logic [VEC_W-1:0] iso_en_o,
  output logic             prog_n_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             err_o
);

  seq_state_e       state_q;
  logic [VEC_W-1:0] rst_q, iso_q;
  logic             prog_n_q, busy_q, ok_q, err_q, part_q;
  logic             fail;

  assign fail          = tick_i && !met_i && last_poll_i;
  assign tmr_restart_o = !waiting_i || (tick_i && met_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rst_q    <= RST_NONE;
      iso_q    <= ISO_CLOSED;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      part_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          busy_q <= 1'b1;
          ok_q   <= 1'b0;
          err_q  <= 1'b0;
          part_q <= partial_i;
          if (partial_i) begin
            state_q <= ST_DONE_WAIT;
          end else begin
            rst_q   <= RST_ALL;
            state_q <= ST_ISO_CLOSE;
          end
        end
        ST_ISO_CLOSE: begin
          iso_q   <= ISO_CLOSED;
          state_q <= ST_ISO_FWD;
        end
        ST_ISO_FWD: begin
          iso_q   <= ISO_FWD;
          state_q <= ST_PROG_REL;
        end
        ST_PROG_REL: begin
          prog_n_q <= 1'b1;
          state_q  <= ST_INIT_HI1;
        end
        ST_INIT_HI1, ST_INIT_LO, ST_INIT_HI2, ST_DONE_WAIT: begin
          if (tick_i && met_i) begin
            unique case (state_q)
              ST_INIT_HI1: begin
                prog_n_q <= 1'b0;
                state_q  <= ST_INIT_LO;
              end
              ST_INIT_LO: begin
                prog_n_q <= 1'b1;
                state_q  <= ST_INIT_HI2;
              end
              ST_INIT_HI2: state_q <= ST_DONE_WAIT;
              default: begin
                if (part_q) begin
                  ok_q    <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_ISO_BOTH;
                end
              end
            endcase
          end else if (fail) begin
            err_q    <= 1'b1;
            busy_q   <= 1'b0;
            prog_n_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_ISO_BOTH: begin
          iso_q   <= ISO_BOTH;
          state_q <= ST_RST_REL;
        end
        ST_RST_REL: begin
          rst_q   <= RST_NONE;
          ok_q    <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign rst_vec_o = rst_q;
  assign iso_en_o  = iso_q;
  assign prog_n_o  = prog_n_q;
  assign busy_o    = busy_q;
  assign ok_o      = ok_q;
  assign err_o     = err_q;

  AST_RST_BEFORE_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !$stable(iso_q) |-> rst_q == RST_ALL); // R2

  AST_STROBE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_q |-> (iso_q == ISO_FWD) && (rst_q == RST_ALL)); // R3

  AST_ERR_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) && !part_q |-> rst_q == RST_ALL && prog_n_q); // R5

  AST_RELEASE_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q == RST_NONE) && ($past(rst_q) == RST_ALL) |-> iso_q == ISO_BOTH); // R6

  AST_PARTIAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && part_q |=> $stable(rst_q) && $stable(iso_q) && $stable(prog_n_q)); // R7

  AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ok_q && !err_q); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && err_q)); // R10

endmodule

// File: rtl/fabric_cfg_seq.sv
module fabric_cfg_seq #(
  parameter int CYC_PER_US = 100,
  parameter int POLL_US    = 20,
  parameter int TIMEOUT_US = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       init_sts_i,
  input  logic       prog_done_i,
  output logic [3:0] rst_vec_o,
  output logic [3:0] iso_en_o,
  output logic       prog_n_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o
);
  import cfgseq_pkg::*;

  localparam int POLL_CYC_RAW  = CYC_PER_US * POLL_US;
  localparam int POLL_CYC      = (POLL_CYC_RAW > 0) ? POLL_CYC_RAW : 1;
  localparam int MAX_POLLS_RAW = TIMEOUT_US / ((POLL_US > 0) ? POLL_US : 1);
  localparam int MAX_POLLS     = (MAX_POLLS_RAW > 0) ? MAX_POLLS_RAW : 1;

  seq_state_e state;
  logic       tick, last_poll, waiting, met, tmr_restart;

  cfgseq_poll_timer #(
    .POLL_CYC  (POLL_CYC),
    .MAX_POLLS (MAX_POLLS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (tmr_restart),
    .tick_o      (tick),
    .last_poll_o (last_poll)
  );

  cfgseq_wait_eval u_eval (
    .state_i   (state),
    .init_i    (init_sts_i),
    .done_i    (prog_done_i),
    .waiting_o (waiting),
    .met_o     (met)
  );

  cfgseq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .partial_i     (partial_i),
    .tick_i        (tick),
    .last_poll_i   (last_poll),
    .waiting_i     (waiting),
    .met_i         (met),
    .state_o       (state),
    .tmr_restart_o (tmr_restart),
    .rst_vec_o     (rst_vec_o),
    .iso_en_o      (iso_en_o),
    .prog_n_o      (prog_n_o),
    .busy_o        (busy_o),
    .ok_o          (ok_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/fabric_cfg_seq_tb_top.sv
module fabric_cfg_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 1;
  localparam int PUS        = 2;
  localparam int TUS        = 20;
  localparam int POLL_CYC   = CPU * PUS;
  localparam int MAX_POLLS  = TUS / PUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       partial = 1'b0;
  logic       init_sts;
  logic       prog_done = 1'b0;
  logic [3:0] rst_vec, iso_en;
  logic       prog_n, busy, ok, err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  string cur_req = "R1";

  logic [14:0] exp_q[$];
  logic [14:0] mdl_last;

  int   fab_mode = 0;
  logic fell = 1'b0;
  logic [2:0] dly = 3'b111;

  always #(CLK_PERIOD/2) clk = ~clk;

  fabric_cfg_seq #(.CYC_PER_US(CPU), .POLL_US(PUS), .TIMEOUT_US(TUS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
    .init_sts_i(init_sts), .prog_done_i(prog_done),
    .rst_vec_o(rst_vec), .iso_en_o(iso_en), .prog_n_o(prog_n),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  function automatic logic [14:0] snap_now();
    return {busy, ok, err, rst_vec, iso_en, prog_n};
  endfunction

  // fabric model: init echoes strobe with delay, or is forced
  initial begin
    init_sts = 1'b1;
    forever begin
      @(negedge clk);
      dly = {dly[1:0], prog_n};
      if (fab_mode == 3 && !dly[2]) fell = 1'b1;
      case (fab_mode)
        1:       init_sts = 1'b0;
        2:       init_sts = 1'b1;
        3:       init_sts = fell ? 1'b0 : dly[2];
        default: init_sts = dly[2];
      endcase
    end
  end

  task automatic chk(input logic cond, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_snap(input logic b, input logic o, input logic e,
                             input logic [3:0] r, input logic [3:0] l, input logic p);
    logic [14:0] s;
    s = {b, o, e, r, l, p};
    if (s != mdl_last) begin
      exp_q.push_back(s);
      mdl_last = s;
    end
  endtask

  // monitor: every output change must match the next expected snapshot
  initial begin
    logic [14:0] last, cur, e;
    last = 15'h0001;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cur = snap_now();
        if (cur != last) begin
          n_cmp++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=no change", cur_req, cur);
          end else begin
            e = exp_q.pop_front();
            if (cur != e) begin
              n_bad++;
              $display("FAIL %s: actual=%0h expected=%0h", cur_req, cur, e);
            end
          end
          last = cur;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic kick(input logic p);
    @(negedge clk);
    start = 1'b1;
    partial = p;
    @(negedge clk);
    start = 1'b0;
    partial = 1'b0;
  endtask

  task automatic wait_idle(output int bcnt);
    bcnt = busy ? 1 : 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
      bcnt++;
    end
  endtask

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic set_fabric(input int mode, input logic done);
    fab_mode = mode;
    fell = 1'b0;
    prog_done = done;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int bc;
    mdl_last = 15'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(snap_now() == 15'h0001, "R1", snap_now(), 15'h0001);

    // full success with a second start (partial) ignored mid-session: R2 R3 R4 R6 R9
    cur_req = "R2/R3/R4/R6/R9 full session";
    set_fabric(0, 1'b1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 0);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hF, 1);
    expect_snap(0, 1, 0, 4'h0, 4'hF, 1);
    kick(1'b0);
    repeat (4) @(negedge clk);
    start = 1'b1; partial = 1'b1;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
    wait_idle(bc);
    chk(ok && !err, "R6", {ok, err}, 2'b10);
    drain("R9");

    // partial success: R7
    cur_req = "R7 partial session";
    expect_snap(1, 0, 0, 4'h0, 4'hF, 1);
    expect_snap(0, 1, 0, 4'h0, 4'hF, 1);
    kick(1'b1);
    wait_idle(bc);
    chk(rst_vec == 4'h0 && iso_en == 4'hF, "R7", {rst_vec, iso_en}, 8'h0F);
    drain("R7");

    // full again from ok state: ok cleared, shifters pass through 0: R10 R3
    cur_req = "R10/R3 repeat full";
    expect_snap(1, 0, 0, 4'hF, 4'hF, 1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 0);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hF, 1);
    expect_snap(0, 1, 0, 4'h0, 4'hF, 1);
    kick(1'b0);
    wait_idle(bc);
    drain("R10");

    // first init wait fails: R5 R11
    cur_req = "R5/R11 init-high timeout";
    set_fabric(1, 1'b1);
    expect_snap(1, 0, 0, 4'hF, 4'hF, 1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(0, 0, 1, 4'hF, 4'hA, 1);
    kick(1'b0);
    wait_idle(bc);
    chk(bc == 3 + POLL_CYC * MAX_POLLS, "R11", bc, 3 + POLL_CYC * MAX_POLLS);
    chk(err && rst_vec == 4'hF, "R5", {err, rst_vec}, 5'h1F);
    drain("R5");

    // init-low wait fails, strobe returns high: R5
    cur_req = "R5 init-low timeout";
    set_fabric(2, 1'b1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 0);
    expect_snap(0, 0, 1, 4'hF, 4'hA, 1);
    kick(1'b0);
    wait_idle(bc);
    chk(prog_n == 1'b1, "R5", prog_n, 1);
    drain("R5");

    // second init-high wait fails: R4 R5
    cur_req = "R4/R5 init-rehigh timeout";
    set_fabric(3, 1'b1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 0);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(0, 0, 1, 4'hF, 4'hA, 1);
    kick(1'b0);
    wait_idle(bc);
    drain("R4");

    // done wait fails in full mode: R8
    cur_req = "R8 full done timeout";
    set_fabric(0, 1'b0);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'h0, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 0);
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(0, 0, 1, 4'hF, 4'hA, 1);
    kick(1'b0);
    wait_idle(bc);
    drain("R8");

    // done wait fails in partial mode: R8 R11
    cur_req = "R8/R11 partial done timeout";
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(0, 0, 1, 4'hF, 4'hA, 1);
    kick(1'b1);
    wait_idle(bc);
    chk(bc == POLL_CYC * MAX_POLLS, "R11", bc, POLL_CYC * MAX_POLLS);
    drain("R8");

    // err is sticky while idle: R10
    cur_req = "R10 sticky err";
    repeat (10) @(negedge clk);
    chk(err && !ok && !busy, "R10", {busy, ok, err}, 3'b001);

    // next start clears err, partial success: R10 R7
    cur_req = "R10/R7 clear on start";
    prog_done = 1'b1;
    expect_snap(1, 0, 0, 4'hF, 4'hA, 1);
    expect_snap(0, 1, 0, 4'hF, 4'hA, 1);
    kick(1'b1);
    wait_idle(bc);
    chk(ok && !err, "R10", {ok, err}, 2'b10);
    drain("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule